// File: doc/BRIEF.md
# Frame-Synced Overhead Elastic Store

This block carries two overhead channels from a write clock domain into a faster, independent read clock domain. Each channel has its own 16-entry by 64-bit storage array and its own pair of location pointers. The write port of each channel is a valid/ready stream qualified by a frame sync pulse, and the read port of each channel is a valid/ready stream as well. Write and read location pointers are kept in binary with an extra wrap bit. They cross between the domains as Gray code through two-flop synchronizers.

A channel accepts words only while its frame sync is present. Presence is tracked by a timer in the write domain. When no sync pulse has been seen for a programmable number of write-clock cycles, the channel's sync-missing flag rises. From then on, both of the channel's pointers stand still and the read data output keeps replaying the last word that was read. When the next sync pulse arrives, the flag clears and reading resumes from the frozen read location, so no stored word is skipped.

Back-pressure rules are as follows. On the write side, a word is taken on a write-clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the channel is full or while its sync is missing, and a source may hold `wr_valid` high for any length of time. On the read side, a word is removed on a read-clock edge where `rd_valid` and `rd_ready` are both high. `rd_data` is meaningful with `rd_valid`, and it holds the last removed word whenever `rd_valid` is low.

Top module: `ovh_elastic_store`

## Requirements
- R1: The two channels are independent. Words written into one channel never appear on the other channel's read port, and each channel returns its words in the order they were written.
- R2: A word is stored on a write-clock edge where `wr_valid` and `wr_ready` are high. A sync pulse on `wr_sync` makes the channel present in that same cycle, so a word offered together with its sync is accepted.
- R3: After 16 unread words, `wr_ready` stays low. A further word offered then is not stored, and only the 16 accepted words are read out.
- R4: After reset, `sync_lost` is 1. It is 0 from the write-clock edge that samples `wr_sync` high. It rises on exactly the SYNC_TIMEOUT-th later edge if none of those edges samples a sync.
- R5: While `sync_lost` is 1 and `wr_sync` is low, `wr_ready` is 0, an offered word is not stored, and the write location does not advance.
- R6: `rd_valid` is high when the channel holds an unread word and its sync is not missing. `rd_data` then shows the oldest unread word, and one word is removed per edge with `rd_valid` and `rd_ready` high.
- R7: While the missing flag is seen in the read domain, `rd_valid` is 0 even if unread words remain, and the read location stays frozen.
- R8: When sync returns, reading resumes at the frozen location, and the first word read is the one after the last word read before the loss.
- R9: Whenever `rd_valid` is low, `rd_data` equals the last word removed from that channel, or 0 if none has been removed since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wr_valid | input | NCH | Per-channel write word offered |
| wr_ready | output | NCH | Per-channel write word can be taken |
| wr_sync | input | NCH | Per-channel frame sync pulse |
| wr_data | input | NCH x DW | Per-channel write word |
| sync_lost | output | NCH | Per-channel sync-missing flag (write domain) |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Read-domain reset, active low, asynchronous |
| rd_valid | output | NCH | Per-channel read word available |
| rd_ready | input | NCH | Per-channel read word taken |
| rd_data | output | NCH x DW | Per-channel read word, or last read word when not valid |

## Verification
The results have different timing. `wr_ready` and `sync_lost` are due in the write domain: `wr_ready` follows its inputs in the same cycle, and `sync_lost` changes at the edge that samples a sync, or exactly SYNC_TIMEOUT edges later. The bench checks both at the write-clock falling edge after a counted number of rising edges. Results that cross domains are different. A newly written word, and the freeze or release of the read side, appear after one write edge plus two or three read edges, so the bench waits a bounded number of read cycles for `rd_valid` before it compares data. The hold behaviour is checked repeatedly across a window of read cycles after the freeze has had time to cross.

// File: rtl/ovh_pkg.sv
package ovh_pkg;

  // Binary to Gray conversion on a 32-bit carrier; callers cast to width.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray to binary conversion on a 32-bit carrier.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/ovh_sync2.sv
module ovh_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ovh_wr_chan.sv
module ovh_wr_chan
  import ovh_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 4,
  parameter int unsigned SYNC_TIMEOUT = 64
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sync,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic          sync_lost,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned CW    = $clog2(SYNC_TIMEOUT + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wbin_nx, rbin_s, fill;
  logic [CW-1:0] idle_cnt;
  logic          full, present, push;

  assign rbin_s  = PW'(gray_to_bin(32'(rgray_s)));
  assign full    = (wbin[AW] != rbin_s[AW]) && (wbin[AW-1:0] == rbin_s[AW-1:0]);
  assign present = !sync_lost || wr_sync;
  assign wr_ready = present && !full;
  assign push    = wr_valid && wr_ready;
  assign wbin_nx = wbin + PW'(1);
  assign fill    = wbin - rbin_s;
  assign rword   = mem[raddr];

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= PW'(bin_to_gray(32'(wbin_nx)));
    end
  end

  // Sync presence timer: restarts on every sync, flags after SYNC_TIMEOUT idle edges.
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      idle_cnt  <= '0;
      sync_lost <= 1'b1;
    end else if (wr_sync) begin
      idle_cnt  <= '0;
      sync_lost <= 1'b0;
    end else if (!sync_lost) begin
      if (idle_cnt == CW'(SYNC_TIMEOUT - 1)) sync_lost <= 1'b1;
      else idle_cnt <= idle_cnt + CW'(1);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    fill <= PW'(DEPTH))
    else $error("write side ran past the read location");

  assert_wptr_frozen_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (sync_lost && !wr_sync) |=> $stable(wbin))
    else $error("write location moved while sync missing");

  assert_lost_clear_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_sync |=> !sync_lost)
    else $error("missing flag not cleared by sync");

  assert_lost_rise_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(sync_lost) |-> !$past(wr_sync))
    else $error("missing flag rose right after a sync");
endmodule

// File: rtl/ovh_rd_chan.sv
module ovh_rd_chan
  import ovh_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 4
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [AW:0]   wgray_s,
  input  logic          lost_s,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] raddr,
  input  logic [DW-1:0] rword,
  output logic [AW:0]   rgray
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx;
  logic [DW-1:0] last_word;
  logic          empty, pop;

  assign empty    = (rgray == wgray_s);
  assign rd_valid = !empty && !lost_s;
  assign pop      = rd_valid && rd_ready;
  assign rbin_nx  = rbin + PW'(1);
  assign raddr    = rbin[AW-1:0];
  assign rd_data  = rd_valid ? rword : last_word;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      last_word <= '0;
    end else if (pop) begin
      rbin      <= rbin_nx;
      rgray     <= PW'(bin_to_gray(32'(rbin_nx)));
      last_word <= rword;
    end
  end

  assert_rptr_frozen_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    lost_s |=> $stable(rbin))
    else $error("read location moved while sync missing");

  assert_hold_last_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_valid |=> (rd_valid || $stable(rd_data)))
    else $error("read data changed while not valid");

  assert_gray_step_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(wgray_s ^ $past(wgray_s)) <= 1)
    else $error("synchronized write location jumped more than one Gray bit");
endmodule

// File: rtl/ovh_elastic_store.sv
module ovh_elastic_store #(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 4,
  parameter int unsigned SYNC_TIMEOUT = 64
) (
  input  logic                    wclk,
  input  logic                    wrst_n,
  input  logic [NCH-1:0]          wr_valid,
  output logic [NCH-1:0]          wr_ready,
  input  logic [NCH-1:0]          wr_sync,
  input  logic [NCH-1:0][DW-1:0]  wr_data,
  output logic [NCH-1:0]          sync_lost,
  input  logic                    rclk,
  input  logic                    rrst_n,
  output logic [NCH-1:0]          rd_valid,
  input  logic [NCH-1:0]          rd_ready,
  output logic [NCH-1:0][DW-1:0]  rd_data
);
  localparam int unsigned PW = AW + 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rword;
    logic          lost_s;

    ovh_wr_chan #(.DW(DW), .AW(AW), .SYNC_TIMEOUT(SYNC_TIMEOUT)) u_wr (
      .wclk(wclk), .wrst_n(wrst_n),
      .wr_valid(wr_valid[c]), .wr_ready(wr_ready[c]),
      .wr_data(wr_data[c]), .wr_sync(wr_sync[c]),
      .rgray_s(rgray_s), .wgray(wgray), .sync_lost(sync_lost[c]),
      .raddr(raddr), .rword(rword)
    );

    ovh_sync2 #(.W(PW), .INIT('0)) u_wsync (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    ovh_sync2 #(.W(1), .INIT(1'b1)) u_lsync (
      .clk(rclk), .rst_n(rrst_n), .d(sync_lost[c]), .q(lost_s)
    );

    ovh_sync2 #(.W(PW), .INIT('0)) u_rsync (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    ovh_rd_chan #(.DW(DW), .AW(AW)) u_rd (
      .rclk(rclk), .rrst_n(rrst_n),
      .wgray_s(wgray_s), .lost_s(lost_s),
      .rd_valid(rd_valid[c]), .rd_ready(rd_ready[c]), .rd_data(rd_data[c]),
      .raddr(raddr), .rword(rword), .rgray(rgray)
    );
  end
endmodule

// File: tb/sim_ovh_elastic_store.sv
`timescale 1ns/1ps
module sim_ovh_elastic_store;
  localparam int NCH = 2;
  localparam int DW  = 64;
  localparam int T   = 64;

  logic                   wclk = 1'b0, rclk = 1'b0;
  logic                   wrst_n = 1'b0, rrst_n = 1'b0;
  logic [NCH-1:0]         wr_valid = '0, wr_sync = '0, rd_ready = '0;
  logic [NCH-1:0][DW-1:0] wr_data = '0;
  logic [NCH-1:0]         wr_ready, sync_lost, rd_valid;
  logic [NCH-1:0][DW-1:0] rd_data;

  int total = 0, bad = 0;
  int kc [NCH];

  // Vector: bit 7 = channel, bits 4:0 = word count.
  localparam logic [7:0] VEC [6] = '{8'h01, 8'h85, 8'h0C, 8'h90, 8'h07, 8'h83};

  always #5 wclk = ~wclk;   // write clock, 100 MHz
  always #2 rclk = ~rclk;   // read clock, 250 MHz

  ovh_elastic_store #(.NCH(NCH), .DW(DW), .AW(4), .SYNC_TIMEOUT(T)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sync(wr_sync), .wr_data(wr_data), .sync_lost(sync_lost),
    .rclk(rclk), .rrst_n(rrst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data)
  );

  function automatic logic [63:0] pat(input int ch, input int k);
    return {8'hA0 + 8'(ch), 24'(k), 32'(k) * 32'h9E3779B1};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int ch, input int n, input bit sync_first);
    for (int i = 0; i < n; i++) begin
      int tries;
      tries = 0;
      @(negedge wclk);
      wr_valid[ch] = 1'b1;
      wr_data[ch]  = pat(ch, kc[ch]);
      wr_sync[ch]  = sync_first && (i == 0);
      #1;
      while (!wr_ready[ch] && tries < 50) begin
        @(negedge wclk); #1; tries++;
      end
      if (tries == 50) chk(1'b0, "R2 write never accepted", 64'(wr_ready[ch]), 64'd1);
      @(posedge wclk);
      kc[ch]++;
    end
    @(negedge wclk);
    wr_valid[ch] = 1'b0;
    wr_sync[ch]  = 1'b0;
  endtask

  task automatic pop(input int ch, input logic [63:0] exp, input string req);
    int tries;
    tries = 0;
    @(negedge rclk);
    while (!rd_valid[ch] && tries < 200) begin
      @(negedge rclk); tries++;
    end
    chk(rd_valid[ch] && rd_data[ch] == exp, req, rd_data[ch], exp);
    rd_ready[ch] = 1'b1;
    @(posedge rclk);
    @(negedge rclk);
    rd_ready[ch] = 1'b0;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    kc[0] = 0; kc[1] = 0;
    repeat (5) @(negedge wclk);
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (3) @(negedge wclk);

    // Reset state (R4, R9, R5)
    chk(sync_lost == 2'b11, "R4 reset flag", 64'(sync_lost), 64'h3);
    chk(rd_valid == 2'b00, "R6 reset rd_valid", 64'(rd_valid), 64'h0);
    chk(rd_data[0] == 64'd0 && rd_data[1] == 64'd0, "R9 reset rd_data", rd_data[0] | rd_data[1], 64'd0);
    chk(wr_ready == 2'b00, "R5 no ready before sync", 64'(wr_ready), 64'h0);

    // Vector table walk: ordering and channel isolation (R1, R2, R6)
    foreach (VEC[v]) begin
      int ch, n;
      ch = int'(VEC[v][7]);
      n  = int'(VEC[v][4:0]);
      base = kc[ch];
      put(ch, n, 1'b1);
      repeat (10) @(negedge rclk);
      chk(rd_valid[1-ch] == 1'b0, "R1 other channel stays empty", 64'(rd_valid), 64'(1 << ch));
      for (int i = 0; i < n; i++) pop(ch, pat(ch, base + i), "R1 R6 in-order read");
    end

    // Exact timeout of the missing flag on channel 1 (R4)
    @(negedge wclk); wr_sync[1] = 1'b1;
    @(posedge wclk);
    @(negedge wclk); wr_sync[1] = 1'b0;
    chk(sync_lost[1] == 1'b0, "R4 cleared by sync", 64'(sync_lost[1]), 64'd0);
    repeat (T - 1) @(posedge wclk);
    @(negedge wclk);
    chk(sync_lost[1] == 1'b0, "R4 still present one edge before timeout", 64'(sync_lost[1]), 64'd0);
    @(posedge wclk);
    @(negedge wclk);
    chk(sync_lost[1] == 1'b1, "R4 raised at timeout", 64'(sync_lost[1]), 64'd1);

    // Freeze and recovery on channel 0 (R5, R7, R8, R9)
    base = kc[0];
    put(0, 4, 1'b1);
    pop(0, pat(0, base), "R6 first word before loss");
    begin
      int tries;
      tries = 0;
      while (!sync_lost[0] && tries < 200) begin @(negedge wclk); tries++; end
    end
    repeat (4) @(negedge rclk);
    chk(rd_valid[0] == 1'b0, "R7 no valid while sync missing", 64'(rd_valid[0]), 64'd0);
    chk(rd_data[0] == pat(0, base), "R7 last word replayed", rd_data[0], pat(0, base));
    @(negedge wclk);
    wr_valid[0] = 1'b1; wr_data[0] = 64'hDEAD_BEEF_0000_0001;
    #1;
    chk(wr_ready[0] == 1'b0, "R5 ready low while sync missing", 64'(wr_ready[0]), 64'd0);
    repeat (3) @(negedge wclk);
    wr_valid[0] = 1'b0;
    repeat (20) @(negedge rclk);
    chk(rd_valid[0] == 1'b0 && rd_data[0] == pat(0, base), "R9 hold over window", rd_data[0], pat(0, base));
    put(0, 1, 1'b1);
    for (int i = 1; i < 5; i++) pop(0, pat(0, base + i), "R8 resume without skip");
    repeat (10) @(negedge rclk);
    chk(rd_valid[0] == 1'b0 && rd_data[0] == pat(0, base + 4), "R5 R9 unsynced word not stored", rd_data[0], pat(0, base + 4));

    // Full channel 1 (R3)
    base = kc[1];
    put(1, 16, 1'b1);
    @(negedge wclk);
    wr_valid[1] = 1'b1; wr_data[1] = 64'h0BAD_0BAD_0BAD_0BAD;
    #1;
    chk(wr_ready[1] == 1'b0, "R3 ready low when full", 64'(wr_ready[1]), 64'd0);
    repeat (4) @(negedge wclk);
    wr_valid[1] = 1'b0;
    for (int i = 0; i < 16; i++) pop(1, pat(1, base + i), "R3 all sixteen words");
    repeat (10) @(negedge rclk);
    chk(rd_valid[1] == 1'b0 && rd_data[1] == pat(1, base + 15), "R3 extra word not stored", rd_data[1], pat(1, base + 15));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule